// File: doc/BRIEF.md
# Peak-Current Trip Conditioner

This block sits between the current-sense comparators of a peak-current-mode converter and its PWM generator. It takes two asynchronous comparator outputs: the main current trip, and a backup over-current trip set to a higher threshold. It turns them into one clean trip event per switching cycle, which the PWM generator uses to end the active pulse. The PWM generator marks the start of each switching cycle with a one-clock strobe. The conditioner then opens a programmable leading-edge blanking window, so the current spike from switching does not cause an early trip.

The main trip is edge sensitive. When its rising edge falls inside the blanking window, the selected mode decides what happens: in ignore mode the edge is dropped, and in defer mode it is held and issued as soon as the window closes. The backup input bypasses blanking and sets a sticky fault flag, which software clears. When the peak-current setpoint code is below a programmable threshold, the whole cycle is skipped. This decision is taken at the cycle start and held until the next one. The analog comparators, the setpoint DAC and slope compensation are outside this block.

Top module: `ipk_trip_cond`

## Requirements
- R1: While rst_ni is low, trip_o, skip_o and fault_o are all 0.
- R2: With blanking length 0 and no skip, the main comparator input rising between two clock edges gives a one-clock trip_o pulse that starts on the third rising clock edge after the input change (two synchroniser flops plus the output register).
- R3: A cycle start sampled at edge E0 with blank_len_i = L blanks the main trip during the L clock intervals after E0. A main rising edge that is synchronised in interval r with r >= L produces trip_o in interval r+1.
- R4: With blank_defer_i = 0 (ignore), a synchronised main rising edge inside the blanking window produces no trip in that cycle, even if the input stays high after the window ends.
- R5: With blank_defer_i = 1 (defer), a synchronised main rising edge inside the window is held and produces trip_o in interval L+1, the first interval after the window closes.
- R6: trip_o is a single-clock pulse, at most one per cycle start. No trip is issued before the first cycle start after reset, and no further comparator activity in the same cycle produces another.
- R7: The backup input is level sensitive and never blanked. While the cycle is armed and not skipped, its synchronised high level gives trip_o in the next interval, even inside the blanking window.
- R8: fault_o is set one clock after the synchronised backup input is high, and it stays set until fault_clr_i is asserted while the backup input is low. When both are active in the same cycle, the set wins.
- R9: At each cycle start, skip_o is loaded with (setpt_i < skip_thr_i) as an unsigned comparison, so equality does not skip. While skip_o is 1, no trip is issued.
- R10: skip_o changes only at a cycle start. Changes to setpt_i or skip_thr_i during a cycle have no effect until the next cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_start_i | input | 1 | One-clock strobe at the start of each switching cycle |
| cmp_main_i | input | 1 | Asynchronous main current-trip comparator |
| cmp_ocp_i | input | 1 | Asynchronous backup over-current comparator |
| blank_len_i | input | LEN_W | Blanking length in clock cycles, 0 disables |
| blank_defer_i | input | 1 | 0 = ignore trips in window, 1 = defer them to window end |
| setpt_i | input | CODE_W | Peak-current setpoint code |
| skip_thr_i | input | CODE_W | Setpoint code below which a cycle is skipped |
| fault_clr_i | input | 1 | Clears the sticky over-current fault |
| trip_o | output | 1 | One-clock trip event to the PWM generator |
| skip_o | output | 1 | Current cycle is skipped |
| fault_o | output | 1 | Sticky backup over-current fault |

## Verification
The bench sweeps blanking length, trip arrival time and blanking mode over all combinations in a small range, and computes the interval in which the trip should appear. A window that is off by one cycle moves or drops the trip, a level-sensitive main input trips late in ignore mode, and a defer latch that is lost or issued early shows up as a missing or misplaced pulse. Further cases check a repeated comparator edge and a held backup level within one cycle, which would give a second pulse in a design that does not disarm. They also cover a backup trip inside the window that a design blanking it would miss, and the setpoint equal to the threshold, where a design using <= would wrongly skip. Changing the setpoint mid-cycle exposes a skip flag that is not latched, and asserting clear together with an active fault exposes a clear that wins over the set.

// File: rtl/ipk_pkg.sv
package ipk_pkg;
  typedef enum logic {
    BLK_IGNORE = 1'b0,
    BLK_DEFER  = 1'b1
  } blk_mode_e;
endpackage

// File: rtl/ipk_sync.sv
module ipk_sync #(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] d_i,
  output logic [N_CH-1:0] q_o
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {sr_q[STAGES-2:0], d_i[ch]};
    end
    assign q_o[ch] = sr_q[STAGES-1];
  end
endmodule

// File: rtl/ipk_blank_tmr.sv
module ipk_blank_tmr #(
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             active_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  AST_BLANK_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_o == ($past(len_i) != '0))); // R3
  AST_BLANK_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !active_o) |=> !active_o); // R3
endmodule

// File: rtl/ipk_trip_arb.sv
module ipk_trip_arb
  import ipk_pkg::*;
#(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              main_s_i,
  input  logic              ocp_s_i,
  input  logic              blank_i,
  input  blk_mode_e         mode_i,
  input  logic [CODE_W-1:0] setpt_i,
  input  logic [CODE_W-1:0] thr_i,
  input  logic              fault_clr_i,
  output logic              trip_o,
  output logic              skip_o,
  output logic              fault_o
);
  logic main_d_q, armed_q, pend_q, skip_q, trip_q, fault_q;
  logic main_rise, live, fire, defer_cap;

  assign main_rise = main_s_i & ~main_d_q;
  // cycle-start interval never trips; new cycle begins on the next edge
  assign live      = armed_q & ~skip_q & ~start_i;
  assign fire      = live & ((main_rise & ~blank_i) | (pend_q & ~blank_i) | ocp_s_i);
  assign defer_cap = live & main_rise & blank_i & (mode_i == BLK_DEFER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_d_q <= 1'b0;
      armed_q  <= 1'b0;
      pend_q   <= 1'b0;
      skip_q   <= 1'b0;
      trip_q   <= 1'b0;
    end else begin
      main_d_q <= main_s_i;
      trip_q   <= fire;
      if (start_i) begin
        armed_q <= 1'b1;
        pend_q  <= 1'b0;
        skip_q  <= (setpt_i < thr_i);
      end else if (fire) begin
        armed_q <= 1'b0;
        pend_q  <= 1'b0;
      end else if (defer_cap) begin
        pend_q  <= 1'b1;
      end
    end
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fault_q <= 1'b0;
    else if (ocp_s_i)     fault_q <= 1'b1;
    else if (fault_clr_i) fault_q <= 1'b0;
  end

  assign trip_o  = trip_q;
  assign skip_o  = skip_q;
  assign fault_o = fault_q;

  AST_TRIP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |=> !trip_o); // R6
  AST_SKIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> !trip_o); // R9
  AST_SKIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(skip_o)); // R10
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_clr_i) |=> fault_o); // R8
  AST_FAULT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocp_s_i |=> fault_o); // R8
  AST_OCP_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !skip_q && !start_i && ocp_s_i) |=> trip_o); // R7
  AST_DEFER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !blank_i && !start_i) |=> trip_o); // R5
  AST_IGNORE_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && mode_i == BLK_IGNORE) |=> !pend_q); // R4
endmodule

// File: rtl/ipk_trip_cond.sv
module ipk_trip_cond
  import ipk_pkg::*;
#(
  parameter int unsigned LEN_W    = 6,
  parameter int unsigned CODE_W   = 10,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_start_i,
  input  logic              cmp_main_i,
  input  logic              cmp_ocp_i,
  input  logic [LEN_W-1:0]  blank_len_i,
  input  logic              blank_defer_i,
  input  logic [CODE_W-1:0] setpt_i,
  input  logic [CODE_W-1:0] skip_thr_i,
  input  logic              fault_clr_i,
  output logic              trip_o,
  output logic              skip_o,
  output logic              fault_o
);
  localparam int unsigned N_CMP = 2;
  localparam int unsigned CH_MAIN = 0;
  localparam int unsigned CH_OCP  = 1;

  logic [N_CMP-1:0] cmp_s;
  logic             blank_act;
  blk_mode_e        mode;

  assign mode = blk_mode_e'(blank_defer_i);

  ipk_sync #(.N_CH(N_CMP), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cmp_ocp_i, cmp_main_i}),
    .q_o    (cmp_s)
  );

  ipk_blank_tmr #(.LEN_W(LEN_W)) u_blank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (cyc_start_i),
    .len_i    (blank_len_i),
    .active_o (blank_act)
  );

  ipk_trip_arb #(.CODE_W(CODE_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cyc_start_i),
    .main_s_i    (cmp_s[CH_MAIN]),
    .ocp_s_i     (cmp_s[CH_OCP]),
    .blank_i     (blank_act),
    .mode_i      (mode),
    .setpt_i     (setpt_i),
    .thr_i       (skip_thr_i),
    .fault_clr_i (fault_clr_i),
    .trip_o      (trip_o),
    .skip_o      (skip_o),
    .fault_o     (fault_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!trip_o && !skip_o && !fault_o)); // R1
endmodule

// File: tb/ipk_trip_cond_bench.sv
module ipk_trip_cond_bench;
  localparam int LEN_W  = 6;
  localparam int CODE_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, cmp_main = 1'b0, cmp_ocp = 1'b0;
  logic [LEN_W-1:0] blank_len = '0;
  logic defer = 1'b0;
  logic [CODE_W-1:0] setpt = '0, thr = '0;
  logic fault_clr = 1'b0;
  logic trip, skip, fault;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ipk_trip_cond #(.LEN_W(LEN_W), .CODE_W(CODE_W)) u_ipk_trip_cond (
    .clk_i(clk), .rst_ni(rst_n), .cyc_start_i(cyc_start),
    .cmp_main_i(cmp_main), .cmp_ocp_i(cmp_ocp),
    .blank_len_i(blank_len), .blank_defer_i(defer),
    .setpt_i(setpt), .skip_thr_i(thr), .fault_clr_i(fault_clr),
    .trip_o(trip), .skip_o(skip), .fault_o(fault)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge of interval 0
  task automatic start_cycle();
    cyc_start = 1'b1;
    tick();
    cyc_start = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int first, cnt, r, exp_first;
    string req;

    // R1 reset state
    repeat (3) tick();
    chk("R1", "trip in reset", int'(trip), 0);
    chk("R1", "skip in reset", int'(skip), 0);
    chk("R1", "fault in reset", int'(fault), 0);
    rst_n = 1'b1;
    setpt = 10'd100;
    thr   = 10'd4;
    repeat (2) tick();

    // R6 no trip before first cycle start
    cnt = 0;
    cmp_main = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (trip) cnt++;
      tick();
    end
    cmp_main = 1'b0;
    chk("R6", "trips before first start", cnt, 0);

    // blanking sweep: length x arrival x mode
    for (int m = 0; m < 2; m++) begin
      for (int L = 0; L < 6; L++) begin
        for (int kin = 0; kin < 7; kin++) begin
          blank_len = LEN_W'(L);
          defer = m[0];
          repeat (4) tick();
          start_cycle();
          first = -1;
          cnt = 0;
          for (int k = 0; k < 25; k++) begin
            if (trip) begin
              cnt++;
              if (first < 0) first = k;
            end
            if (k == kin) cmp_main = 1'b1;
            if (k == kin + 6) cmp_main = 1'b0;
            tick();
          end
          r = kin + 2;
          if (r >= L)  exp_first = r + 1;
          else if (m == 1) exp_first = L + 1;
          else exp_first = -1;
          if (L == 0)       req = "R2";
          else if (r >= L)  req = "R3";
          else if (m == 1)  req = "R5";
          else              req = "R4";
          chk(req, $sformatf("first trip interval L=%0d kin=%0d mode=%0d", L, kin, m), first, exp_first);
          chk("R6", $sformatf("trip count L=%0d kin=%0d mode=%0d", L, kin, m), cnt, (exp_first < 0) ? 0 : 1);
        end
      end
    end

    // R6 repeated edges and backup level in one cycle
    blank_len = '0;
    defer = 1'b0;
    repeat (4) tick();
    start_cycle();
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (trip) cnt++;
      if (k == 0)  cmp_main = 1'b1;
      if (k == 4)  cmp_main = 1'b0;
      if (k == 8)  cmp_main = 1'b1;
      if (k == 12) cmp_ocp = 1'b1;
      tick();
    end
    cmp_main = 1'b0;
    cmp_ocp = 1'b0;
    chk("R6", "pulses in cycle with repeated activity", cnt, 1);
    repeat (4) tick();
    fault_clr = 1'b1;
    tick();
    fault_clr = 1'b0;

    // R7 backup trips inside window; R8 sticky fault
    blank_len = LEN_W'(5);
    repeat (4) tick();
    start_cycle();
    first = -1;
    for (int k = 0; k < 12; k++) begin
      if (trip && first < 0) first = k;
      if (k == 3) chk("R8", "fault set after backup", int'(fault), 1);
      if (k == 0) cmp_ocp = 1'b1;
      if (k == 6) cmp_ocp = 1'b0;
      tick();
    end
    chk("R7", "backup trip interval in window", first, 3);
    repeat (4) tick();
    chk("R8", "fault sticky", int'(fault), 1);
    cmp_ocp = 1'b1;
    repeat (4) tick();
    fault_clr = 1'b1;
    tick();
    fault_clr = 1'b0;
    chk("R8", "set wins over clear", int'(fault), 1);
    cmp_ocp = 1'b0;
    repeat (4) tick();
    fault_clr = 1'b1;
    tick();
    fault_clr = 1'b0;
    chk("R8", "fault cleared", int'(fault), 0);

    // R9 / R10 skip sweep around threshold 4
    blank_len = '0;
    thr = 10'd4;
    for (int s = 0; s < 8; s++) begin
      setpt = CODE_W'(s);
      repeat (4) tick();
      start_cycle();
      chk("R9", $sformatf("skip flag setpt=%0d", s), int'(skip), (s < 4) ? 1 : 0);
      cnt = 0;
      for (int k = 0; k < 12; k++) begin
        if (trip) cnt++;
        if (k == 0) cmp_main = 1'b1;
        if (k == 5) setpt = CODE_W'(7 - s);
        if (k == 8) chk("R10", $sformatf("skip held setpt=%0d", s), int'(skip), (s < 4) ? 1 : 0);
        tick();
      end
      cmp_main = 1'b0;
      chk("R9", $sformatf("trips setpt=%0d", s), cnt, (s < 4) ? 0 : 1);
    end

    summary();
    $finish;
  end
endmodule